// File: doc/BRIEF.md
# DDR2 Power-Up Initialization Sequencer

This block runs once after a synchronous reset and brings a DDR2 memory controller and its PHY into service. It drives a register-write port into the controller and issues a fixed series of writes. The first starts the memory clock in the PHY. The next two reset the PHY and kick off calibration. Twelve JEDEC-style command words follow: deselect, precharges, extended and base mode-register loads, and refreshes. Last come the timing, latency and configuration words. Settle waits of a programmable length fall between the steps. When the last write has been accepted, the block raises `done` and keeps it high.

Each write is presented with valid, address and data and is held unchanged until the controller raises ready. The mode value and the three final words are fixed at build time through parameters. Asserting reset at any point abandons the run and starts again from the first wait.

Top module: `ddr2_boot_seq`

## Requirements
- R1: While `rst` is high and in the cycle after it, `wr_valid` and `done` are low; a reset in the middle of a run restarts the whole sequence from its first wait.
- R2: After reset is released, `wr_valid` stays low for exactly DELAY_CYCLES cycles, then the first write goes to offset 0x00 (PHY clock setup) with data 0x0000_0001 (bit 0 = clock enable).
- R3: After the next wait of DELAY_CYCLES, offset 0x04 (PHY control) is written with 0x0000_0003 (bit 0 = PHY reset, bit 1 = calibration reset), and then, with no idle cycle between them, with 0x0000_0004 (bit 2 = calibration start).
- R4: Every table command goes to offset 0x08 as one word: bits [31:24] zero, bits [23:16] the command code, bits [15:0] the argument.
- R5: The twelve commands go out exactly once each, in this order. Command codes: deselect 0x00, precharge 0x01, ext-mode-2 0x02, ext-mode-3 0x03, ext-mode 0x04, mode 0x05, refresh 0x06. Argument flags: all-banks 0x0400, DLL on 0x0001, DLL reset 0x0100, OCD default 0x0380, OCD exit 0x0000. The sequence is deselect/0; precharge/all-banks; ext-mode-2/0; ext-mode-3/0; ext-mode/DLL on; mode/DLL reset; precharge/all-banks; refresh/0; refresh/0; mode/MODE_VALUE[15:0]; ext-mode/(OCD default|DLL on); ext-mode/(OCD exit|DLL on|MODE_VALUE[31:16]).
- R6: Before the first command and after every command, `wr_valid` is low for exactly DELAY_CYCLES cycles.
- R7: After the wait that follows the last command, TIMING_WORD goes to offset 0x0C, LATENCY_WORD to 0x10 and CONFIG_WORD to 0x14, back to back with no idle cycles.
- R8: While `wr_valid` is high and `wr_ready` is low, `wr_valid`, `wr_addr` and `wr_data` hold their values into the next cycle.
- R9: `done` rises in the cycle after the configuration write is accepted. It then stays high with `wr_valid` low until the next reset.
- R10: A full run makes exactly 18 accepted writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high; restarts the sequence |
| wr_valid | output | 1 | A register write is being offered |
| wr_addr | output | ADDR_W | Register byte offset of the offered write |
| wr_data | output | 32 | Data of the offered write |
| wr_ready | input | 1 | The controller takes the write in this cycle |
| done | output | 1 | The sequence has finished |

## Verification
The hardest situation to reach is a reset that arrives partway through the command table, after some commands have already gone out. It must discard all progress, and the full 18-write run must follow with correct waits. The bench first completes an uninterrupted run. It then resets and lets six writes be accepted before it resets again. Throughout, ready is stalled in an irregular pattern, so writes are held across several cycles. Idle gaps are counted only while valid is low, so the stalls do not disturb the delay check.

// File: rtl/ddr2_boot_pkg.sv
package ddr2_boot_pkg;

    typedef enum logic [1:0] {
        ST_WAIT  = 2'd0,
        ST_WRITE = 2'd1,
        ST_DONE  = 2'd2
    } seq_state_e;

    localparam int unsigned NUM_CMDS  = 12;
    localparam int unsigned CMD_BASE  = 3;
    localparam int unsigned NUM_STEPS = CMD_BASE + NUM_CMDS + 3;
    localparam int unsigned STEP_W    = $clog2(NUM_STEPS);
    localparam int unsigned CIDX_W    = $clog2(NUM_CMDS);

    // register byte offsets inside the controller
    localparam logic [7:0] OFS_PHY_CLK  = 8'h00;
    localparam logic [7:0] OFS_PHY_CTL  = 8'h04;
    localparam logic [7:0] OFS_CMD      = 8'h08;
    localparam logic [7:0] OFS_TIMING   = 8'h0C;
    localparam logic [7:0] OFS_LATENCY  = 8'h10;
    localparam logic [7:0] OFS_CONFIG   = 8'h14;

    // PHY control bits
    localparam logic [31:0] PHY_CLK_ON     = 32'h0000_0001;
    localparam logic [31:0] PHY_RST_BOTH   = 32'h0000_0003;
    localparam logic [31:0] PHY_CAL_GO     = 32'h0000_0004;

    // command codes
    localparam logic [7:0] OP_DESEL = 8'h00;
    localparam logic [7:0] OP_PRE   = 8'h01;
    localparam logic [7:0] OP_XMR2  = 8'h02;
    localparam logic [7:0] OP_XMR3  = 8'h03;
    localparam logic [7:0] OP_XMR   = 8'h04;
    localparam logic [7:0] OP_MR    = 8'h05;
    localparam logic [7:0] OP_REF   = 8'h06;

    // argument flags
    localparam logic [15:0] ARG_ALL_BANKS = 16'h0400;
    localparam logic [15:0] ARG_DLL_ON    = 16'h0001;
    localparam logic [15:0] ARG_DLL_RESET = 16'h0100;
    localparam logic [15:0] ARG_OCD_DFLT  = 16'h0380;
    localparam logic [15:0] ARG_OCD_EXIT  = 16'h0000;

    typedef struct packed {
        seq_state_e        state;
        logic [STEP_W-1:0] step;
        logic              done;
    } seq_regs_t;

endpackage

// File: rtl/boot_wait_timer.sv
module boot_wait_timer
    import ddr2_boot_pkg::*;
#(
    parameter int unsigned DELAY_CYCLES = 40000,
    localparam int unsigned CNT_W = $clog2(DELAY_CYCLES + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic arm,
    output logic expired
);

    localparam logic [CNT_W-1:0] RELOAD = CNT_W'(DELAY_CYCLES - 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (arm) begin
            cnt_d = RELOAD;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= RELOAD;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/boot_cmd_table.sv
module boot_cmd_table
    import ddr2_boot_pkg::*;
#(
    parameter logic [31:0] MODE_VALUE = 32'h0000_0A52
) (
    input  logic [CIDX_W-1:0] idx,
    output logic [7:0]        op,
    output logic [15:0]       arg
);

    always_comb begin
        op  = OP_DESEL;
        arg = 16'h0000;
        case (idx)
            CIDX_W'(0):  begin op = OP_DESEL; arg = 16'h0000;                                   end
            CIDX_W'(1):  begin op = OP_PRE;   arg = ARG_ALL_BANKS;                              end
            CIDX_W'(2):  begin op = OP_XMR2;  arg = 16'h0000;                                   end
            CIDX_W'(3):  begin op = OP_XMR3;  arg = 16'h0000;                                   end
            CIDX_W'(4):  begin op = OP_XMR;   arg = ARG_DLL_ON;                                 end
            CIDX_W'(5):  begin op = OP_MR;    arg = ARG_DLL_RESET;                              end
            CIDX_W'(6):  begin op = OP_PRE;   arg = ARG_ALL_BANKS;                              end
            CIDX_W'(7):  begin op = OP_REF;   arg = 16'h0000;                                   end
            CIDX_W'(8):  begin op = OP_REF;   arg = 16'h0000;                                   end
            CIDX_W'(9):  begin op = OP_MR;    arg = MODE_VALUE[15:0];                           end
            CIDX_W'(10): begin op = OP_XMR;   arg = ARG_OCD_DFLT | ARG_DLL_ON;                  end
            CIDX_W'(11): begin op = OP_XMR;   arg = ARG_OCD_EXIT | ARG_DLL_ON | MODE_VALUE[31:16]; end
            default:     begin op = OP_DESEL; arg = 16'h0000;                                   end
        endcase
    end

endmodule

// File: rtl/boot_step_map.sv
module boot_step_map
    import ddr2_boot_pkg::*;
#(
    parameter int unsigned ADDR_W       = 8,
    parameter logic [31:0] MODE_VALUE   = 32'h0000_0A52,
    parameter logic [31:0] TIMING_WORD  = 32'h0000_0000,
    parameter logic [31:0] LATENCY_WORD = 32'h0000_0000,
    parameter logic [31:0] CONFIG_WORD  = 32'h0000_0000
) (
    input  logic [STEP_W-1:0] step,
    output logic [ADDR_W-1:0] addr,
    output logic [31:0]       data,
    output logic              settle_after,
    output logic              last
);

    localparam logic [STEP_W-1:0] S_PHY_CLK = STEP_W'(0);
    localparam logic [STEP_W-1:0] S_RST     = STEP_W'(1);
    localparam logic [STEP_W-1:0] S_CAL     = STEP_W'(2);
    localparam logic [STEP_W-1:0] S_CMD0    = STEP_W'(CMD_BASE);
    localparam logic [STEP_W-1:0] S_CMDN    = STEP_W'(CMD_BASE + NUM_CMDS - 1);
    localparam logic [STEP_W-1:0] S_TIM     = STEP_W'(CMD_BASE + NUM_CMDS);
    localparam logic [STEP_W-1:0] S_LAT     = STEP_W'(CMD_BASE + NUM_CMDS + 1);
    localparam logic [STEP_W-1:0] S_CFG     = STEP_W'(CMD_BASE + NUM_CMDS + 2);

    logic [CIDX_W-1:0] cidx;
    logic [7:0]        op;
    logic [15:0]       arg;

    assign cidx = CIDX_W'(step - S_CMD0);

    boot_cmd_table #(
        .MODE_VALUE(MODE_VALUE)
    ) u_table (
        .idx(cidx),
        .op (op),
        .arg(arg)
    );

    always_comb begin
        addr = ADDR_W'(OFS_CMD);
        data = {8'h00, op, arg};
        case (step)
            S_PHY_CLK: begin addr = ADDR_W'(OFS_PHY_CLK); data = PHY_CLK_ON;   end
            S_RST:     begin addr = ADDR_W'(OFS_PHY_CTL); data = PHY_RST_BOTH; end
            S_CAL:     begin addr = ADDR_W'(OFS_PHY_CTL); data = PHY_CAL_GO;   end
            S_TIM:     begin addr = ADDR_W'(OFS_TIMING);  data = TIMING_WORD;  end
            S_LAT:     begin addr = ADDR_W'(OFS_LATENCY); data = LATENCY_WORD; end
            S_CFG:     begin addr = ADDR_W'(OFS_CONFIG);  data = CONFIG_WORD;  end
            default:   ;
        endcase
    end

    // a wait follows the clock start, the calibration start and each command
    assign settle_after = (step == S_PHY_CLK) || ((step >= S_CAL) && (step <= S_CMDN));
    assign last         = (step == S_CFG);

endmodule

// File: rtl/ddr2_boot_seq.sv
module ddr2_boot_seq
    import ddr2_boot_pkg::*;
#(
    parameter int unsigned ADDR_W       = 8,
    parameter int unsigned DELAY_CYCLES = 40000,
    parameter logic [31:0] MODE_VALUE   = 32'h0000_0A52,
    parameter logic [31:0] TIMING_WORD  = 32'h2233_4455,
    parameter logic [31:0] LATENCY_WORD = 32'h0000_0033,
    parameter logic [31:0] CONFIG_WORD  = 32'h0000_0208
) (
    input  logic              clk,
    input  logic              rst,
    output logic              wr_valid,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [31:0]       wr_data,
    input  logic              wr_ready,
    output logic              done
);

    seq_regs_t r_d, r_q;
    logic      arm;
    logic      expired;
    logic      settle_after;
    logic      last;

    boot_wait_timer #(
        .DELAY_CYCLES(DELAY_CYCLES)
    ) u_timer (
        .clk    (clk),
        .rst    (rst),
        .arm    (arm),
        .expired(expired)
    );

    boot_step_map #(
        .ADDR_W      (ADDR_W),
        .MODE_VALUE  (MODE_VALUE),
        .TIMING_WORD (TIMING_WORD),
        .LATENCY_WORD(LATENCY_WORD),
        .CONFIG_WORD (CONFIG_WORD)
    ) u_map (
        .step        (r_q.step),
        .addr        (wr_addr),
        .data        (wr_data),
        .settle_after(settle_after),
        .last        (last)
    );

    always_comb begin
        r_d = r_q;
        arm = 1'b0;
        case (r_q.state)
            ST_WAIT: begin
                if (expired) begin
                    r_d.state = ST_WRITE;
                end
            end
            ST_WRITE: begin
                if (wr_ready) begin
                    if (last) begin
                        r_d.state = ST_DONE;
                        r_d.done  = 1'b1;
                    end else begin
                        r_d.step = r_q.step + STEP_W'(1);
                        if (settle_after) begin
                            r_d.state = ST_WAIT;
                            arm       = 1'b1;
                        end
                    end
                end
            end
            default: begin
                r_d.state = ST_DONE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q.state <= ST_WAIT;
            r_q.step  <= '0;
            r_q.done  <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign wr_valid = (r_q.state == ST_WRITE);
    assign done     = r_q.done;

endmodule

// File: rtl/boot_seq_checker.sv
module boot_seq_checker
    import ddr2_boot_pkg::*;
#(
    parameter int unsigned ADDR_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_valid,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [31:0]       wr_data,
    input logic              wr_ready,
    input logic              done
);

    logic accept;
    assign accept = wr_valid && wr_ready;

    // R1
    reset_idle_chk: assert property (@(posedge clk)
        rst |=> (!wr_valid && !done));

    // R8
    hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr) && $stable(wr_data)));

    // R9
    done_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> done);

    // R9
    done_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> !wr_valid);

    // R3
    cal_follows_rst_chk: assert property (@(posedge clk) disable iff (rst)
        (accept && wr_addr == ADDR_W'(OFS_PHY_CTL) && wr_data == PHY_RST_BOTH)
        |=> (wr_valid && wr_addr == ADDR_W'(OFS_PHY_CTL) && wr_data == PHY_CAL_GO));

    // R6
    cmd_settle_chk: assert property (@(posedge clk) disable iff (rst)
        (accept && wr_addr == ADDR_W'(OFS_CMD)) |=> !wr_valid);

    // R4
    cmd_upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && wr_addr == ADDR_W'(OFS_CMD)) |-> (wr_data[31:24] == 8'h00));

endmodule

bind ddr2_boot_seq boot_seq_checker #(
    .ADDR_W(ADDR_W)
) u_boot_seq_checker (
    .clk     (clk),
    .rst     (rst),
    .wr_valid(wr_valid),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .wr_ready(wr_ready),
    .done    (done)
);

// File: tb/ddr2_boot_seq_test.sv
module ddr2_boot_seq_test;

    localparam int          CLK_PERIOD = 10;
    localparam int          DLY        = 5;
    localparam logic [31:0] MODE_V     = 32'h0004_0632;
    localparam logic [31:0] TIM_V      = 32'h1234_5678;
    localparam logic [31:0] LAT_V      = 32'h0000_0033;
    localparam logic [31:0] CFG_V      = 32'h00A5_5A01;

    typedef struct {
        logic [7:0]  addr;
        logic [31:0] data;
        int          gap;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_valid;
    logic [7:0]  wr_addr;
    logic [31:0] wr_data;
    logic        wr_ready = 1'b0;
    logic        done;

    exp_t exp_q[$];
    int   checks = 0;
    int   fails  = 0;
    int   idle   = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    ddr2_boot_seq #(
        .ADDR_W      (8),
        .DELAY_CYCLES(DLY),
        .MODE_VALUE  (MODE_V),
        .TIMING_WORD (TIM_V),
        .LATENCY_WORD(LAT_V),
        .CONFIG_WORD (CFG_V)
    ) uut (
        .clk     (clk),
        .rst     (rst),
        .wr_valid(wr_valid),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .wr_ready(wr_ready),
        .done    (done)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic push(input logic [7:0] a, input logic [31:0] d, input int g, input string t);
        exp_t e;
        e.addr = a; e.data = d; e.gap = g; e.tag = t;
        exp_q.push_back(e);
    endtask

    function automatic logic [31:0] cw(input logic [7:0] op, input logic [15:0] arg);
        return {8'h00, op, arg};
    endfunction

    // driver: the whole expected write list of one run
    task automatic load_expected();
        exp_q.delete();
        push(8'h00, 32'h1, DLY, "R2");
        push(8'h04, 32'h3, DLY, "R3");
        push(8'h04, 32'h4, 0,   "R3");
        push(8'h08, cw(8'h00, 16'h0000), DLY, "R5");
        push(8'h08, cw(8'h01, 16'h0400), DLY, "R5");
        push(8'h08, cw(8'h02, 16'h0000), DLY, "R5");
        push(8'h08, cw(8'h03, 16'h0000), DLY, "R5");
        push(8'h08, cw(8'h04, 16'h0001), DLY, "R5");
        push(8'h08, cw(8'h05, 16'h0100), DLY, "R5");
        push(8'h08, cw(8'h01, 16'h0400), DLY, "R6");
        push(8'h08, cw(8'h06, 16'h0000), DLY, "R6");
        push(8'h08, cw(8'h06, 16'h0000), DLY, "R4");
        push(8'h08, cw(8'h05, 16'h0632), DLY, "R4");
        push(8'h08, cw(8'h04, 16'h0381), DLY, "R5");
        push(8'h08, cw(8'h04, 16'h0005), DLY, "R5");
        push(8'h0C, TIM_V, DLY, "R7");
        push(8'h10, LAT_V, 0,   "R7");
        push(8'h14, CFG_V, 0,   "R7");
    endtask

    // monitor: compares each accepted write against the scoreboard
    always @(negedge clk) begin
        if (rst) begin
            idle = 0;
        end else if (wr_valid && wr_ready) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R10", "write beyond end", {56'h0, wr_addr}, 64'h0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                check(wr_addr == e.addr, e.tag, "addr", {56'h0, wr_addr}, {56'h0, e.addr});
                check(wr_data == e.data, e.tag, "data", {32'h0, wr_data}, {32'h0, e.data});
                check(idle == e.gap, (e.gap == 0) ? e.tag : "R6", "idle gap",
                      64'(idle), 64'(e.gap));
            end
            idle = 0;
        end else if (!wr_valid && !done) begin
            idle++;
        end
    end

    // ready pattern with irregular stalls
    initial begin
        int cyc = 0;
        forever begin
            @(posedge clk);
            #1;
            cyc++;
            wr_ready = ((cyc % 5) != 2) && ((cyc % 23) > 3);
        end
    end

    task automatic wait_done();
        while (!done) @(negedge clk);
        #1;
    endtask

    task automatic end_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected done");
        end_run();
    end

    initial begin
        // R1: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(!wr_valid && !done, "R1", "outputs in reset", {62'h0, wr_valid, done}, 64'h0);
        load_expected();
        @(posedge clk);
        #1 rst = 1'b0;

        // run 1: uninterrupted
        wait_done();
        check(exp_q.size() == 0, "R10", "writes left", 64'(exp_q.size()), 64'h0);
        check(done == 1'b1, "R9", "done after config write", {63'h0, done}, 64'h1);
        repeat (25) @(negedge clk);
        check(done && !wr_valid, "R9", "done held, port quiet", {62'h0, done, wr_valid}, 64'h2);

        // run 2: reset partway through the command table
        @(posedge clk);
        #1 rst = 1'b1;
        @(negedge clk);
        load_expected();
        @(posedge clk);
        #1 rst = 1'b0;
        while (exp_q.size() > 12) @(negedge clk);
        @(posedge clk);
        #1 rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check(!wr_valid && !done, "R1", "outputs after mid-run reset", {62'h0, wr_valid, done}, 64'h0);
        load_expected();
        @(posedge clk);
        #1 rst = 1'b0;
        wait_done();
        check(exp_q.size() == 0, "R1", "full rerun after reset", 64'(exp_q.size()), 64'h0);
        check(done == 1'b1, "R9", "done after rerun", {63'h0, done}, 64'h1);
        repeat (10) @(negedge clk);
        end_run();
    end

endmodule